// File: doc/BRIEF.md
# Next Instruction Priority Dispatcher

At the end of every instruction the control sequencer has to choose its next stop. The choice can be the second half of an interrupt cycle, the halt loop, a meter service, the start of an interrupt, the statistics-tracking path, a trap, a fetch of the next instruction from the accumulator file, or the normal start of the next instruction. This block makes that choice. It folds seven machine condition flags into one 4-bit dispatch offset. The sequencer adds that offset to a fixed base address.

The conditions have a fixed priority. For the tracking, accumulator and normal cases, a pending trap sets the low bit of the offset, so each of these cases has an even and an odd offset. A pending trap is therefore still seen when tracking is enabled. The odd tracking offset carries it to the trap path.

A dispatch may not be taken in the cycle right after the next-instruction fetch is issued, because the accumulator-source flag needs one cycle to settle. The block enforces this rule itself. A request that arrives in that cycle raises `stall` for the cycle and is held internally. It is then taken on the next cycle that does not directly follow a fetch.

When a request is accepted, all condition flags are sampled on that clock edge. The registered offset appears one cycle later, together with a one-cycle valid pulse.

Top module: `nxt_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `disp_valid` and `stall` are 0 and `disp_ofs` is 0.
- R2: When `irq_cycle` is 1 in the accepting cycle, the offset is 0 (octal 0), whatever the other flags are.
- R3: Otherwise, when `run_on` is 0, the offset is 2 (octal 2).
- R4: Otherwise, when `meter_req` is 1, the offset is 4 (octal 4).
- R5: Otherwise, when `irq_req` is 1, the offset is 6 (octal 6).
- R6: Otherwise, when `track_en` is 1, the offset is 8 (octal 10). If `trap_req` is also 1, the offset is 9 (octal 11), so the trap is not lost.
- R7: Otherwise, the base is 14 (octal 16) when `acc_src` is 1 and 10 (octal 12) when it is 0. `trap_req` sets bit 0 of the offset, giving 15 (octal 17) or 11 (octal 13).
- R8: The offset carried with a valid pulse is always one of 0, 2, 4, 6, 8, 9, 10, 11, 14 or 15. `disp_valid` is high for exactly one cycle, in the cycle after each accepted request. Back-to-back accepted requests give back-to-back pulses.
- R9: A request that is pending in the cycle right after a cycle with `fetch_go` high raises `stall` in that cycle and is not accepted. It is accepted on the next cycle that does not follow a fetch, and the flags are sampled in that accepting cycle.
- R10: With no request pending, `disp_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_req | input | 1 | Dispatch request at the end of an instruction |
| fetch_go | input | 1 | Next-instruction fetch issued this cycle |
| irq_cycle | input | 1 | Interrupt cycle in progress |
| run_on | input | 1 | Run flip-flop; 0 means halted |
| meter_req | input | 1 | Meter service request |
| irq_req | input | 1 | Interrupt request ready |
| track_en | input | 1 | Statistics tracking enabled |
| trap_req | input | 1 | Trap pending from the previous instruction |
| acc_src | input | 1 | Next instruction comes from the accumulator file |
| disp_ofs | output | 4 | Registered dispatch offset |
| disp_valid | output | 1 | One-cycle strobe that marks a new offset |
| stall | output | 1 | Pending request held back by the fetch interlock |

## Verification
A wrong priority order or a lost trap bit shows as a wrong `disp_ofs` in the very cycle `disp_valid` pulses, one cycle after acceptance. A corrupted hold state in the fetch interlock shows in one of three ways. A pulse may be missing, a pulse may appear too early (in the cycle right after the stall), or a pulse may appear twice. The offset would then also reflect flags from the wrong cycle, so the bench changes the flags between the stall cycle and the accepting cycle.

// File: rtl/nxt_dispatch_pkg.sv
`timescale 1ns/1ps
package nxt_dispatch_pkg;

    localparam int OFS_W = 4;

    typedef logic [OFS_W-1:0] ofs_t;

    // Dispatch offsets; the sequencer decodes these positions.
    localparam ofs_t OFS_IRQ_CYC = ofs_t'(0);
    localparam ofs_t OFS_HALT    = ofs_t'(2);
    localparam ofs_t OFS_METER   = ofs_t'(4);
    localparam ofs_t OFS_IRQ     = ofs_t'(6);
    localparam ofs_t OFS_TRACK   = ofs_t'(8);
    localparam ofs_t OFS_NORMAL  = ofs_t'(10);
    localparam ofs_t OFS_ACC     = ofs_t'(14);

    typedef struct packed {
        logic irq_cycle;
        logic run_on;
        logic meter_req;
        logic irq_req;
        logic track_en;
        logic trap_req;
        logic acc_src;
    } cond_t;

    function automatic logic ofs_legal(input ofs_t o);
        return (o == OFS_IRQ_CYC) || (o == OFS_HALT) || (o == OFS_METER) ||
               (o == OFS_IRQ) || (o == OFS_TRACK) || (o == (OFS_TRACK | ofs_t'(1))) ||
               (o == OFS_NORMAL) || (o == (OFS_NORMAL | ofs_t'(1))) ||
               (o == OFS_ACC) || (o == (OFS_ACC | ofs_t'(1)));
    endfunction

endpackage

// File: rtl/nxt_prio_enc.sv
`timescale 1ns/1ps
module nxt_prio_enc
    import nxt_dispatch_pkg::*;
(
    input  cond_t cond,
    output ofs_t  ofs
);

    always_comb begin
        if (cond.irq_cycle) begin
            ofs = OFS_IRQ_CYC;
        end else if (!cond.run_on) begin
            ofs = OFS_HALT;
        end else if (cond.meter_req) begin
            ofs = OFS_METER;
        end else if (cond.irq_req) begin
            ofs = OFS_IRQ;
        end else if (cond.track_en) begin
            // trap folds into bit 0 so it is never dropped (R6)
            ofs = OFS_TRACK | ofs_t'(cond.trap_req);
        end else begin
            ofs = (cond.acc_src ? OFS_ACC : OFS_NORMAL) | ofs_t'(cond.trap_req);
        end
    end

endmodule

// File: rtl/nxt_fetch_gate.sv
`timescale 1ns/1ps
module nxt_fetch_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_go,
    input  logic req,
    output logic accept,
    output logic stall
);

    typedef struct packed {
        logic fetch;   // a fetch was issued last cycle
        logic held;    // a stalled request waits
    } gate_t;

    gate_t gate_d, gate_q;
    logic  pend;

    always_comb begin
        pend        = req | gate_q.held;
        stall       = pend & gate_q.fetch;
        accept      = pend & ~gate_q.fetch;
        gate_d      = gate_q;
        gate_d.fetch = fetch_go;
        gate_d.held  = stall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // R9: a stalled request is retried, never dropped
    assert_stall_retried_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (accept || stall));

    // R9: no acceptance in the cycle right after a fetch
    assert_no_accept_after_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> !accept);

endmodule

// File: rtl/nxt_dispatch.sv
`timescale 1ns/1ps
module nxt_dispatch
    import nxt_dispatch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_req,
    input  logic             fetch_go,
    input  logic             irq_cycle,
    input  logic             run_on,
    input  logic             meter_req,
    input  logic             irq_req,
    input  logic             track_en,
    input  logic             trap_req,
    input  logic             acc_src,
    output logic [OFS_W-1:0] disp_ofs,
    output logic             disp_valid,
    output logic             stall
);

    typedef struct packed {
        ofs_t ofs;
        logic vld;
    } out_t;

    cond_t cond;
    ofs_t  enc_ofs;
    logic  accept;
    out_t  out_d, out_q;

    assign cond = '{irq_cycle: irq_cycle, run_on: run_on, meter_req: meter_req,
                    irq_req: irq_req, track_en: track_en, trap_req: trap_req,
                    acc_src: acc_src};

    nxt_prio_enc u_enc (
        .cond (cond),
        .ofs  (enc_ofs)
    );

    nxt_fetch_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_go (fetch_go),
        .req      (disp_req),
        .accept   (accept),
        .stall    (stall)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = accept;
        if (accept) begin
            out_d.ofs = enc_ofs;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign disp_ofs   = out_q.ofs;
    assign disp_valid = out_q.vld;

    // R8: only the legal offset set leaves the block
    assert_ofs_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ofs_legal(disp_ofs));

    // R2: interrupt cycle wins over everything
    assert_irq_cycle_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && irq_cycle |=> disp_ofs == OFS_IRQ_CYC);

    // R6: pending trap under tracking reaches the odd tracking offset
    assert_trap_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && run_on && !irq_cycle && !meter_req && !irq_req && track_en && trap_req
        |=> disp_ofs[0]);

    // R9: a stalled cycle produces no strobe in the next cycle
    assert_stall_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !disp_valid);

    // R10: with nothing requested and nothing held, no strobe follows
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_req && !stall && !accept |=> !disp_valid);

endmodule

// File: tb/nxt_dispatch_test.sv
`timescale 1ns/1ps
module nxt_dispatch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_req = 1'b0;
    logic       fetch_go = 1'b0;
    logic       irq_cycle = 1'b0, run_on = 1'b1, meter_req = 1'b0, irq_req = 1'b0;
    logic       track_en = 1'b0, trap_req = 1'b0, acc_src = 1'b0;
    logic [3:0] disp_ofs;
    logic       disp_valid, stall;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nxt_dispatch uut (
        .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .fetch_go(fetch_go),
        .irq_cycle(irq_cycle), .run_on(run_on), .meter_req(meter_req),
        .irq_req(irq_req), .track_en(track_en), .trap_req(trap_req),
        .acc_src(acc_src), .disp_ofs(disp_ofs), .disp_valid(disp_valid),
        .stall(stall)
    );

    // {irq_cycle, run_on, meter_req, irq_req, track_en, trap_req, acc_src, expected offset}
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        11'b1011111_0000,  // R2
        11'b0011111_0010,  // R3
        11'b0111111_0100,  // R4
        11'b0101111_0110,  // R5
        11'b0100100_1000,  // R6
        11'b0100111_1001,  // R6 trap kept
        11'b0100000_1010,  // R7 normal
        11'b0100010_1011,  // R7 normal + trap
        11'b0100001_1110,  // R7 accumulator
        11'b0100011_1111,  // R7 accumulator + trap
        11'b1100000_0000,  // R2
        11'b0110000_0100   // R4
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 10:       return "R2";
            1:           return "R3";
            2, 11:       return "R4";
            3:           return "R5";
            4, 5:        return "R6";
            default:     return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cond(input logic [6:0] c);
        {irq_cycle, run_on, meter_req, irq_req, track_en, trap_req, acc_src} = c;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset
        repeat (3) @(negedge clk);
        check("R1 valid in reset", disp_valid, 0);
        check("R1 stall in reset", stall, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", disp_valid, 0);
        check("R1 offset after reset", disp_ofs, 0);

        // idle: no request, no strobe (R10)
        repeat (3) begin
            @(negedge clk);
            check("R10 idle valid", disp_valid, 0);
        end

        // vector table, back-to-back requests (R8)
        for (int i = 0; i < NV; i++) begin
            set_cond(VEC[i][10:4]);
            disp_req = 1'b1;
            @(negedge clk);
            check({vec_tag(i), " valid"}, disp_valid, 1);
            check({vec_tag(i), " offset"}, disp_ofs, VEC[i][3:0]);
        end
        disp_req = 1'b0;
        @(negedge clk);
        check("R8 single pulse", disp_valid, 0);

        // fetch interlock (R9): flags change between stall and accept
        set_cond(7'b0100000);
        fetch_go = 1'b1;
        @(negedge clk);
        fetch_go = 1'b0;
        disp_req = 1'b1;
        set_cond(7'b0110000);      // meter in the stalled cycle
        #1;
        check("R9 stall raised", stall, 1);
        @(negedge clk);
        disp_req = 1'b0;
        check("R9 no valid after stall", disp_valid, 0);
        check("R9 stall one cycle", stall, 0);
        set_cond(7'b0101000);      // interrupt request in accepting cycle
        @(negedge clk);
        check("R9 held request valid", disp_valid, 1);
        check("R9 sampled at acceptance", disp_ofs, 6);
        set_cond(7'b0100000);
        @(negedge clk);
        check("R9 R8 no duplicate pulse", disp_valid, 0);

        // two fetches in a row keep the request stalled (R9)
        fetch_go = 1'b1;
        @(negedge clk);
        disp_req = 1'b1;
        #1;
        check("R9 stall with fetch again", stall, 1);
        @(negedge clk);
        disp_req = 1'b0;
        fetch_go = 1'b0;
        #1;
        check("R9 still stalled", stall, 1);
        check("R9 no valid yet", disp_valid, 0);
        set_cond(7'b0100001);
        @(negedge clk);
        check("R9 not yet valid", disp_valid, 0);
        @(negedge clk);
        check("R9 late accept valid", disp_valid, 1);
        check("R9 late accept offset", disp_ofs, 14);
        @(negedge clk);
        check("R10 quiet after", disp_valid, 0);

        // a fetch with no request leaves nothing behind (R10)
        fetch_go = 1'b1;
        @(negedge clk);
        fetch_go = 1'b0;
        #1;
        check("R10 no stall without request", stall, 0);
        @(negedge clk);
        check("R10 no valid without request", disp_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule